// File: doc/BRIEF.md
# CSR Access Privilege Guard

This block decides, in pure combinational logic, whether a single access to a control and status register is illegal. It sits beside the register file of a hart. Each cycle it sees the 12-bit register address, the hart's current privilege level, whether the access writes, and the machine-level and supervisor-level counter-enable words. It raises one fault flag, which the surrounding pipeline turns into an illegal-instruction trap.

Three independent rules feed the flag.

- **Minimum-privilege rule.** The minimum privilege encoded in the address is compared against the current level with a bitwise mask test.
- **Counter rule.** Reads of the user-visible counter window (cycle, time, retired-instruction count and the hardware performance counters) are further gated per counter by the enable words. The gating is selected by the hart's current level.
- **Read-only rule.** Writes into the read-only quarter of the address space are always refused.

Register storage, the counters themselves, trap entry and decode are handled elsewhere.

Top module: `csr_priv_guard`

## Requirements
- R1: The fault is raised when (effective level AND address bits [9:8]) differs from address bits [9:8]. The level encodings are user 2'b00, supervisor 2'b01 and machine 2'b11. So machine mode passes every required level, and user mode passes only 2'b00.
- R2: A current level of 2'b10 is reserved and grants nothing beyond user. It behaves exactly like 2'b00 in every rule.
- R3: In machine mode, every access to the counter window 0xC00 to 0xC1F passes the counter rule, whatever the enable words hold.
- R4: In supervisor mode, a counter-window access faults when bit addr[4:0] of the machine enable word is 0. It passes the counter rule when that bit is 1.
- R5: In user mode (supervisor mode implemented), a counter-window access passes the counter rule only when bit addr[4:0] is 1 in both the machine and the supervisor enable words.
- R6: Addresses outside 0xC00 to 0xC1F are never affected by the enable words. For example, a user read of 0xC20 or 0xC80 with both words zero does not fault.
- R7: Any write to an address whose bits [11:10] are 2'b11 faults, at every privilege level. A write outside that quarter is refused only by the other rules.
- R8: The flag depends only on the present inputs and settles in the same cycle, with no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr_i | input | 12 | Address of the register being accessed |
| hart_lvl_i | input | 2 | Current privilege level of the hart |
| is_write_i | input | 1 | 1 when the access writes the register |
| m_cnt_en_i | input | 32 | Machine-level per-counter enable word |
| s_cnt_en_i | input | 32 | Supervisor-level per-counter enable word |
| access_fault_o | output | 1 | 1 when the access is illegal |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between any input and the flag. The bench therefore applies each input set at the falling clock edge and compares the flag one time unit later, still inside that cycle and well away from the rising edge. The counter sweep covers every index, every level and all four enable-bit combinations. In each case the unselected enable bits are driven to the opposite value, so a wrong bit selection shows up in the flag.

// File: rtl/csr_guard_pkg.sv
// Package: shared privilege-level type and the level normalisation helper
// for the CSR access guard. Assumes the two-bit level encoding in which
// user is 2'b00, supervisor 2'b01 and machine 2'b11.
package csr_guard_pkg;

    typedef enum logic [1:0] {
        LVL_USER  = 2'b00,
        LVL_SUPER = 2'b01,
        LVL_RSVD  = 2'b10,
        LVL_MACH  = 2'b11
    } lvl_e;

    // Map the raw level to the level that actually grants rights.
    // The reserved code grants nothing beyond user.
    function automatic lvl_e eff_level(input logic [1:0] raw);
        lvl_e res;
        case (raw)
            2'b01:   res = LVL_SUPER;
            2'b11:   res = LVL_MACH;
            default: res = LVL_USER;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/csr_guard_min_lvl.sv
// Module: minimum-privilege test. Compares the effective hart level with
// the required level taken from the address field, using a bitwise mask.
// Assumes the caller has already normalised the reserved level code.
module csr_guard_min_lvl
    import csr_guard_pkg::*;
(
    input  lvl_e       eff_lvl_i,
    input  logic [1:0] need_lvl_i,
    output logic       short_o
);

    // Fault when the masked level does not reproduce the requirement.
    always_comb begin
        short_o = ((eff_lvl_i & need_lvl_i) != need_lvl_i);
    end

endmodule

// File: rtl/csr_guard_ctr_gate.sv
// Module: counter-window gating. Detects an address inside the user counter
// window and applies the per-counter enables selected by the hart's current
// (effective) level. Assumes the window is NUM_CTR entries starting at
// CTR_BASE, aligned so the low address bits index the enable words.
// S_IMPL selects whether the supervisor enables take part in user gating.
module csr_guard_ctr_gate
    import csr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_CTR  = 32,
    parameter int unsigned CTR_BASE = 12'hC00,
    parameter bit          S_IMPL   = 1'b1
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  lvl_e               eff_lvl_i,
    input  logic [NUM_CTR-1:0] m_en_i,
    input  logic [NUM_CTR-1:0] s_en_i,
    output logic               in_window_o,
    output logic               block_o
);

    localparam int unsigned IDX_W = $clog2(NUM_CTR);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(CTR_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(CTR_BASE + NUM_CTR - 1);

    logic [IDX_W-1:0] idx;
    logic             m_bit;
    logic             s_bit;
    logic             user_ok;

    // Window hit and selected enable bits.
    always_comb begin
        in_window_o = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
        idx         = addr_i[IDX_W-1:0];
        m_bit       = m_en_i[idx];
        s_bit       = s_en_i[idx];
    end

    // User-level permission depends on whether supervisor mode exists.
    generate
        if (S_IMPL) begin : g_user_two_level
            assign user_ok = m_bit & s_bit;
        end else begin : g_user_one_level
            logic unused_s;
            assign unused_s = s_bit;
            assign user_ok  = m_bit;
        end
    endgenerate

    // Apply the gating chosen by the current level.
    always_comb begin
        block_o = 1'b0;
        if (in_window_o) begin
            case (eff_lvl_i)
                LVL_MACH:  block_o = 1'b0;
                LVL_SUPER: block_o = ~m_bit;
                default:   block_o = ~user_ok;
            endcase
        end
    end

endmodule

// File: rtl/csr_guard_ro_write.sv
// Module: read-only space write test. Flags any write whose address lies
// in the quarter of the CSR space reserved for read-only registers.
// Assumes that quarter is marked by the top two address bits being 2'b11.
module csr_guard_ro_write (
    input  logic [1:0] space_i,
    input  logic       is_write_i,
    output logic       ro_hit_o
);

    // Writes into the read-only quarter are refused.
    always_comb begin
        ro_hit_o = is_write_i && (space_i == 2'b11);
    end

endmodule

// File: rtl/csr_priv_guard.sv
// Module: top of the CSR access guard. Normalises the hart level, runs the
// three independent legality rules and ORs them into one fault flag.
// Assumes a 12-bit address with the required level in bits [9:8] and the
// read-only marker in bits [11:10]. Purely combinational: no clock, no reset.
module csr_priv_guard #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_CTR  = 32,
    parameter int unsigned CTR_BASE = 12'hC00,
    parameter bit          S_IMPL   = 1'b1
) (
    input  logic [ADDR_W-1:0]  csr_addr_i,
    input  logic [1:0]         hart_lvl_i,
    input  logic               is_write_i,
    input  logic [NUM_CTR-1:0] m_cnt_en_i,
    input  logic [NUM_CTR-1:0] s_cnt_en_i,
    output logic               access_fault_o
);

    import csr_guard_pkg::*;

    localparam int unsigned LVL_LSB   = ADDR_W - 4;
    localparam int unsigned SPACE_LSB = ADDR_W - 2;

    lvl_e eff_lvl;
    logic min_short;
    logic in_window;
    logic ctr_block;
    logic ro_hit;

    // Reserved level grants user rights only.
    always_comb begin
        eff_lvl = eff_level(hart_lvl_i);
    end

    csr_guard_min_lvl i_min_lvl (
        .eff_lvl_i  (eff_lvl),
        .need_lvl_i (csr_addr_i[LVL_LSB+1:LVL_LSB]),
        .short_o    (min_short)
    );

    csr_guard_ctr_gate #(
        .ADDR_W   (ADDR_W),
        .NUM_CTR  (NUM_CTR),
        .CTR_BASE (CTR_BASE),
        .S_IMPL   (S_IMPL)
    ) i_ctr_gate (
        .addr_i      (csr_addr_i),
        .eff_lvl_i   (eff_lvl),
        .m_en_i      (m_cnt_en_i),
        .s_en_i      (s_cnt_en_i),
        .in_window_o (in_window),
        .block_o     (ctr_block)
    );

    csr_guard_ro_write i_ro_write (
        .space_i    (csr_addr_i[SPACE_LSB+1:SPACE_LSB]),
        .is_write_i (is_write_i),
        .ro_hit_o   (ro_hit)
    );

    // Any failing rule makes the access illegal.
    always_comb begin
        access_fault_o = min_short | ctr_block | ro_hit;
    end

endmodule

// File: rtl/csr_priv_guard_chk.sv
// Module: assertion checker for csr_priv_guard, attached by bind. Uses
// immediate assertions because the guarded block has no clock; each check
// relates the top ports to the flags produced by separate sub-blocks.
module csr_priv_guard_chk #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned NUM_CTR = 32
) (
    input logic [ADDR_W-1:0]  csr_addr_i,
    input logic [1:0]         hart_lvl_i,
    input logic               is_write_i,
    input logic [NUM_CTR-1:0] m_cnt_en_i,
    input logic [NUM_CTR-1:0] s_cnt_en_i,
    input logic               access_fault_o,
    input logic               in_window,
    input logic               min_short,
    input logic               ro_hit
);

    localparam int unsigned IDX_W   = $clog2(NUM_CTR);
    localparam int unsigned LVL_LSB = ADDR_W - 4;

    logic [IDX_W-1:0] idx;
    logic [1:0]       need;

    // Decode the fields the properties refer to.
    always_comb begin
        idx  = csr_addr_i[IDX_W-1:0];
        need = csr_addr_i[LVL_LSB+1:LVL_LSB];
    end

    // Property set on the settled combinational result.
    always_comb begin
        if (min_short) begin
            p_min_rule_fault_r1: assert (access_fault_o);
        end
        if (hart_lvl_i == 2'b10 && need != 2'b00) begin
            p_rsvd_as_user_r2: assert (access_fault_o);
        end
        if (hart_lvl_i == 2'b11 && in_window && !is_write_i) begin
            p_mach_ctr_free_r3: assert (!access_fault_o);
        end
        if (hart_lvl_i == 2'b01 && in_window && !m_cnt_en_i[idx]) begin
            p_super_ctr_blocked_r4: assert (access_fault_o);
        end
        if (hart_lvl_i == 2'b00 && in_window && !is_write_i
            && m_cnt_en_i[idx] && s_cnt_en_i[idx]) begin
            p_user_ctr_both_r5: assert (!access_fault_o);
        end
        if (!in_window && !min_short && !ro_hit) begin
            p_outside_ungated_r6: assert (!access_fault_o);
        end
        if (is_write_i && csr_addr_i[ADDR_W-1:ADDR_W-2] == 2'b11) begin
            p_ro_write_fault_r7: assert (access_fault_o);
        end
    end

endmodule

bind csr_priv_guard csr_priv_guard_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_CTR (NUM_CTR)
) i_chk (
    .csr_addr_i     (csr_addr_i),
    .hart_lvl_i     (hart_lvl_i),
    .is_write_i     (is_write_i),
    .m_cnt_en_i     (m_cnt_en_i),
    .s_cnt_en_i     (s_cnt_en_i),
    .access_fault_o (access_fault_o),
    .in_window      (in_window),
    .min_short      (min_short),
    .ro_hit         (ro_hit)
);

// File: tb/test_csr_priv_guard.sv
// Bench: directed scenarios for csr_priv_guard, one task each. Inputs change
// at the falling edge; the flag is compared one time unit later.
module test_csr_priv_guard;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [11:0] csr_addr_i;
    logic [1:0]  hart_lvl_i;
    logic        is_write_i;
    logic [31:0] m_cnt_en_i;
    logic [31:0] s_cnt_en_i;
    logic        access_fault_o;

    int checks;
    int failures;
    bit done;

    csr_priv_guard i_csr_priv_guard (
        .csr_addr_i     (csr_addr_i),
        .hart_lvl_i     (hart_lvl_i),
        .is_write_i     (is_write_i),
        .m_cnt_en_i     (m_cnt_en_i),
        .s_cnt_en_i     (s_cnt_en_i),
        .access_fault_o (access_fault_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirements.
    function automatic bit model(input logic [11:0] a, input logic [1:0] lvl,
                                 input logic wr, input logic [31:0] me,
                                 input logic [31:0] se);
        logic [1:0] eff;
        logic [1:0] req;
        bit f;
        eff = (lvl == 2'b10) ? 2'b00 : lvl;              // R2
        req = a[9:8];
        f = ((eff & req) != req);                         // R1
        if (a >= 12'hC00 && a <= 12'hC1F) begin
            if (eff == 2'b01) f = f | !me[a[4:0]];        // R4
            else if (eff == 2'b00) f = f | !(me[a[4:0]] & se[a[4:0]]); // R5
        end
        if (wr && a[11:10] == 2'b11) f = 1'b1;            // R7
        return f;
    endfunction

    // Apply one access and compare the flag within the same cycle (R8).
    task automatic apply_check(input string req, input logic [11:0] a,
                               input logic [1:0] lvl, input logic wr,
                               input logic [31:0] me, input logic [31:0] se);
        bit exp;
        @(negedge clk);
        csr_addr_i = a;
        hart_lvl_i = lvl;
        is_write_i = wr;
        m_cnt_en_i = me;
        s_cnt_en_i = se;
        exp = model(a, lvl, wr, me, se);
        #1;
        checks++;
        if (access_fault_o !== exp) begin
            failures++;
            $display("FAIL %s addr=%h lvl=%b wr=%b me=%h se=%h actual=%b expected=%b",
                     req, a, lvl, wr, me, se, access_fault_o, exp);
        end
    endtask

    // Idle inputs during reset give no fault.
    task automatic t_reset;
        apply_check("R1 reset idle", 12'h000, 2'b00, 1'b0, 32'h0, 32'h0);
    endtask

    // Address-encoded minimum level against every current level.
    task automatic t_min_rule;
        for (int l = 0; l < 4; l++) begin
            for (int r = 0; r < 4; r++) begin
                apply_check(l == 2 ? "R2 reserved level" : "R1 min level",
                            {2'b00, 2'(r), 8'h45}, 2'(l), 1'b0, 32'h0, 32'h0);
            end
        end
    endtask

    // Every counter index, every level, every enable-bit combination.
    task automatic t_ctr_sweep;
        for (int i = 0; i < 32; i++) begin
            for (int l = 0; l < 4; l++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [31:0] me;
                    logic [31:0] se;
                    me = c[0] ? (32'h1 << i) : ~(32'h1 << i);
                    se = c[1] ? (32'h1 << i) : ~(32'h1 << i);
                    apply_check(l == 3 ? "R3 machine counter" :
                                l == 1 ? "R4 supervisor counter" :
                                l == 2 ? "R2 reserved counter" : "R5 user counter",
                                12'hC00 + 12'(i), 2'(l), 1'b0, me, se);
                end
            end
        end
    endtask

    // Addresses next to the window ignore the enables.
    task automatic t_outside_window;
        apply_check("R6 above window", 12'hC20, 2'b00, 1'b0, 32'h0, 32'h0);
        apply_check("R6 high half",    12'hC80, 2'b00, 1'b0, 32'h0, 32'h0);
        apply_check("R6 high half s",  12'hC9F, 2'b01, 1'b0, 32'h0, 32'h0);
        apply_check("R6 user space",   12'h01F, 2'b00, 1'b0, 32'h0, 32'h0);
    endtask

    // Writes into the read-only quarter always fault.
    task automatic t_ro_write;
        for (int l = 0; l < 4; l++) begin
            apply_check("R7 ro write cnt", 12'hC00, 2'(l), 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
            apply_check("R7 ro write s",   12'hD10, 2'(l), 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
            apply_check("R7 ro write m",   12'hF11, 2'(l), 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        end
        apply_check("R7 rw write m", 12'h305, 2'b11, 1'b1, 32'h0, 32'h0);
        apply_check("R7 rw write s", 12'h140, 2'b01, 1'b1, 32'h0, 32'h0);
    endtask

    // Flag follows a mid-run enable change in the same cycle.
    task automatic t_same_cycle;
        apply_check("R8 enable on",  12'hC02, 2'b01, 1'b0, 32'h4, 32'h0);
        apply_check("R8 enable off", 12'hC02, 2'b01, 1'b0, 32'h0, 32'h0);
        apply_check("R8 enable on2", 12'hC02, 2'b01, 1'b0, 32'h4, 32'h0);
    endtask

    // Ends a hung run as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        checks     = 0;
        failures   = 0;
        done       = 1'b0;
        rst_n      = 1'b0;
        csr_addr_i = '0;
        hart_lvl_i = '0;
        is_write_i = 1'b0;
        m_cnt_en_i = '0;
        s_cnt_en_i = '0;
        t_reset();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_min_rule();
        t_ctr_sweep();
        t_outside_window();
        t_ro_write();
        t_same_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule